// File: doc/BRIEF.md
# Register-Driven I2C Master Byte Engine

This block is an I2C bus master that software steers through four byte-wide registers: a control register, a status register, a data register and a clock divider. Setting the master bit puts a START on the bus, and a write-one to the restart bit inserts a repeated START. Byte transfers have no separate command. Writing the data register sends a byte when the direction bit selects transmit. Reading the data register returns the most recently received byte and, when the direction bit selects receive, starts the next reception at the same time.

The engine drives SCL and SDA as open-drain pull-down enables. Every SCL high and low phase is timed by the divider. A byte ends on the falling edge of the ninth clock: the engine raises a byte-done flag and records the acknowledge. Between bytes the engine parks with SCL held low until software issues the next command. Clearing the master bit from that parked state releases the bus with a STOP.

The first byte written after any START is the address byte: bits 7..1 carry the target address and bit 0 the read/write flag. An awaiting-address status bit shows when the engine expects that byte. The address byte is sent like any other byte, most significant bit first. Before collecting the last received byte, software turns the direction bit back to transmit so that the read does not start another reception.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, the data register (address 2) reads 0x00, control (address 0) and status (address 1) read 0x00, the divider (address 3) reads its reset parameter, and both scl_oe and sda_oe are 0.
- R2: Writing 1 to control bit 0 (master) while idle produces a START: SDA falls while SCL is released, and status bit 1 (busy) reads 1 from then until the STOP completes.
- R3: A data-register write while control bit 1 (direction, 1 = transmit) is 1 and the engine is parked sends the byte MSB first on eight SCL pulses, releases SDA for the ninth pulse, and stores the sampled ninth bit in status bit 2 (0 = acknowledged, 1 = no acknowledge).
- R4: Status bit 0 (byte done) sets on the falling edge of the ninth SCL pulse of every byte. Writing 1 to status bit 0 clears it, and writing 0 there leaves it set.
- R5: Status bit 3 (awaiting address) sets when a START or repeated START completes and clears when the next byte transmission launches. The address byte carries the address in bits 7..1 and the read/write flag in bit 0, and it is sent like data.
- R6: A data-register read while the direction bit is 0 returns the previously received byte and launches reception of the next one. The eight bits are sampled while SCL is high, MSB first, and the data register shows the new byte once byte done sets.
- R7: During reception the engine pulls SDA low on the ninth pulse (ACK) unless control bit 2 (final NACK) was 1 at launch, in which case SDA stays released.
- R8: A data-register read while the direction bit is 1 starts no transfer: SCL stays low, no SCL edge occurs and byte done stays clear. This lets software collect the last received byte after switching to transmit.
- R9: Reading the data register never returns a transmitted byte. It returns only the last byte received.
- R10: Clearing the master bit while parked produces a STOP: SDA rises while SCL is released. After the STOP both enables are 0 and busy reads 0.
- R11: Writing 1 to control bit 3 (restart, reads as 0) while parked produces a repeated START without an intermediate STOP.
- R12: Each SCL high and low phase of a bit lasts P system clocks, where P = divider + 1 for a divider of 1 or more and P = 2 for a divider of 0.
- R13: SDA changes while SCL is released only to form a START or a STOP, so no other START or STOP appears on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle (data reads have side effects) |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 divider |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register, valid in the strobe cycle |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The bench runs a bus model that acknowledges or refuses bytes at random and supplies random receive data. It checks every bit seen on SCL rising edges against the written or supplied byte. A design that launched a receive on a transmit-direction read would leave SCL edges and a set byte-done flag during the quiet window after the final read. A design that let a written byte reach the data register would fail the read-back checks. The bench measures SCL phase widths with the divider at 0 and at random larger values, which exposes a divider that is off by one or ignores the floor of 2. It also counts every START and STOP on the bus: an SDA change while SCL is high during data, or a missing restart, changes those totals.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  localparam int DW    = 8;
  localparam int DIV_W = 8;
  localparam int IDX_W = 4;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;
  localparam logic [1:0] RA_DIV  = 2'd3;

  localparam int CB_MASTER = 0;
  localparam int CB_TX     = 1;
  localparam int CB_NACK   = 2;
  localparam int CB_RSTA   = 3;

  localparam int SB_DONE = 0;
  localparam int SB_BUSY = 1;
  localparam int SB_NAK  = 2;
  localparam int SB_ADDR = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BLO, ST_BHI,
    ST_SLO, ST_SHI, ST_SEND, ST_RLO, ST_RHI
  } eng_state_t;

  // clocks per SCL phase; floor of 2 so SDA can move one clock after SCL falls
  function automatic logic [DIV_W:0] phase_len(input logic [DIV_W-1:0] div);
    if (div == '0) return (DIV_W+1)'(2);
    return {1'b0, div} + (DIV_W+1)'(1);
  endfunction

  // SDA pull-down for one bit slot: slot 8 is the acknowledge slot
  function automatic logic slot_drive(input logic rx, input logic [IDX_W-1:0] idx,
                                      input logic msb, input logic nack);
    if (idx == IDX_W'(8)) return rx ? !nack : 1'b0;
    return rx ? 1'b0 : !msb;
  endfunction
endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer
  import i2c_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W:0] cnt;

  assign tick = run && (cnt == phase_len(div) - (DIV_W+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + (DIV_W+1)'(1);
  end

  // R12: no phase is shorter than two clocks
  assert_phase_min_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $stable(div)) |=> !tick)
    else $error("phase shorter than two clocks");
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import i2c_eng_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          master,
  input  logic          tx_go,
  input  logic          rx_go,
  input  logic          rs_go,
  input  logic          nack_req,
  input  logic [DW-1:0] tx_byte,
  input  logic          sda_in,
  output logic          run,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          parked,
  output logic          busy,
  output logic          rx_mode,
  output logic          start_done,
  output logic          byte_end,
  output logic [DW-1:0] shift_q
);
  eng_state_t       state;
  logic [IDX_W-1:0] bit_idx;
  logic             nack_lat;
  logic             sda_q;
  logic             sda_next;
  logic             bus_edge_ok;

  assign scl_oe     = (state == ST_HOLD) || (state == ST_BLO) ||
                      (state == ST_SLO)  || (state == ST_RLO);
  assign run        = (state != ST_IDLE) && (state != ST_HOLD);
  assign parked     = (state == ST_HOLD);
  assign busy       = (state != ST_IDLE);
  assign start_done = (state == ST_START) && tick;
  assign byte_end   = (state == ST_BHI) && tick && (bit_idx == IDX_W'(8));
  assign sda_oe     = sda_q;
  // states where SDA may move under a released SCL
  assign bus_edge_ok = (state == ST_START) || (state == ST_SEND);

  always_comb begin
    case (state)
      ST_START, ST_SLO, ST_SHI: sda_next = 1'b1;
      ST_HOLD:                  sda_next = sda_q;
      ST_BLO, ST_BHI:           sda_next = slot_drive(rx_mode, bit_idx, shift_q[DW-1], nack_lat);
      default:                  sda_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_idx  <= '0;
      shift_q  <= '0;
      rx_mode  <= 1'b0;
      nack_lat <= 1'b0;
      sda_q    <= 1'b0;
    end else begin
      sda_q <= sda_next;
      case (state)
        ST_IDLE:  if (master) state <= ST_START;
        ST_START: if (tick) state <= ST_HOLD;
        ST_HOLD: begin
          if (!master)    state <= ST_SLO;
          else if (rs_go) state <= ST_RLO;
          else if (tx_go) begin
            state   <= ST_BLO;
            shift_q <= tx_byte;
            rx_mode <= 1'b0;
            bit_idx <= '0;
          end else if (rx_go) begin
            state    <= ST_BLO;
            rx_mode  <= 1'b1;
            nack_lat <= nack_req;
            bit_idx  <= '0;
          end
        end
        ST_BLO: if (tick) state <= ST_BHI;
        ST_BHI: if (tick) begin
          if (bit_idx == IDX_W'(8)) state <= ST_HOLD;
          else begin
            shift_q <= {shift_q[DW-2:0], sda_in};
            bit_idx <= bit_idx + IDX_W'(1);
            state   <= ST_BLO;
          end
        end
        ST_SLO:  if (tick) state <= ST_SHI;
        ST_SHI:  if (tick) state <= ST_SEND;
        ST_SEND: if (tick) state <= ST_IDLE;
        ST_RLO:  if (tick) state <= ST_RHI;
        ST_RHI:  if (tick) state <= ST_START;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13: with SCL released, SDA only moves while forming START or STOP
  assert_sda_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && !bus_edge_ok) |-> $stable(sda_oe))
    else $error("SDA moved while SCL high");

  // R7: acknowledge slot of a receive follows the latched final-NACK request
  assert_rx_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BHI && bit_idx == IDX_W'(8) && rx_mode) |-> (sda_oe == !nack_lat))
    else $error("wrong acknowledge drive");
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in
);
  logic             ctrl_master, ctrl_tx, ctrl_nack;
  logic [DIV_W-1:0] div_q;
  logic             done_q, nak_q, addr_wait;
  logic [DW-1:0]    rx_data;

  logic wr_ctrl, wr_stat, wr_data, wr_div, rd_data;
  logic tx_go, rx_go, rs_go;
  logic tick, run, parked, busy, rx_mode, start_done, byte_end;
  logic [DW-1:0] shift_q;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_data = reg_wr && (reg_addr == RA_DATA);
  assign wr_div  = reg_wr && (reg_addr == RA_DIV);
  assign rd_data = reg_rd && (reg_addr == RA_DATA);

  // byte transfers are side effects of data accesses, gated by direction
  assign tx_go = wr_data && ctrl_tx;
  assign rx_go = rd_data && !ctrl_tx;
  assign rs_go = wr_ctrl && reg_wdata[CB_RSTA];

  i2c_phase_timer u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
  );

  i2c_byte_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .master(ctrl_master),
    .tx_go(tx_go), .rx_go(rx_go), .rs_go(rs_go), .nack_req(ctrl_nack),
    .tx_byte(reg_wdata), .sda_in(sda_in), .run(run), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .parked(parked), .busy(busy), .rx_mode(rx_mode),
    .start_done(start_done), .byte_end(byte_end), .shift_q(shift_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_master <= 1'b0;
      ctrl_tx     <= 1'b0;
      ctrl_nack   <= 1'b0;
      div_q       <= DIV_RESET;
      done_q      <= 1'b0;
      nak_q       <= 1'b0;
      addr_wait   <= 1'b0;
      rx_data     <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_master <= reg_wdata[CB_MASTER];
        ctrl_tx     <= reg_wdata[CB_TX];
        ctrl_nack   <= reg_wdata[CB_NACK];
      end
      if (wr_div) div_q <= reg_wdata;
      if (byte_end)                           done_q <= 1'b1;
      else if (wr_stat && reg_wdata[SB_DONE]) done_q <= 1'b0;
      if (byte_end && !rx_mode) nak_q   <= sda_in;
      if (byte_end && rx_mode)  rx_data <= shift_q;
      if (start_done)              addr_wait <= 1'b1;
      else if (tx_go && parked)    addr_wait <= 1'b0;
      else if (!busy)              addr_wait <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CB_MASTER] = ctrl_master;
        reg_rdata[CB_TX]     = ctrl_tx;
        reg_rdata[CB_NACK]   = ctrl_nack;
      end
      RA_STAT: begin
        reg_rdata[SB_DONE] = done_q;
        reg_rdata[SB_BUSY] = busy;
        reg_rdata[SB_NAK]  = nak_q;
        reg_rdata[SB_ADDR] = addr_wait;
      end
      RA_DATA: reg_rdata = rx_data;
      default: reg_rdata = div_q;
    endcase
  end

  // R8: a data read in transmit direction keeps the engine parked
  assert_no_rx_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && ctrl_tx && parked && ctrl_master && !rs_go) |=> parked)
    else $error("transmit-direction read launched a transfer");

  // R4: byte done rises together with the ninth SCL fall
  assert_done_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $rose(scl_oe))
    else $error("byte done not aligned to SCL fall");

  // R2: busy begins with SCL released (START phase)
  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !scl_oe)
    else $error("busy rose outside START");

  // R10: after STOP both lines are released
  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!scl_oe && !sda_oe))
    else $error("bus not released after STOP");
endmodule

// File: tb/tb_i2c_byte_engine.sv
`timescale 1ns/1ps
module tb_i2c_byte_engine;
  localparam logic [7:0] DIVR = 8'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, sda_in;
  logic slave_low = 1'b0;

  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slave_low);
  assign sda_in = sda_line;

  i2c_byte_engine #(.DIV_RESET(DIVR)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int starts = 0, stops = 0, falls = 0;
  logic [8:0] mon_sh = '0;
  time t_rise = 0, t_fall = 0, last_high = 0, last_low = 0;
  logic [7:0] cur_div = DIVR;

  always @(posedge scl_line) begin
    mon_sh = {mon_sh[7:0], sda_line};
    last_low = $time - t_fall;
    t_rise = $time;
  end
  always @(negedge scl_line) begin
    last_high = $time - t_rise;
    t_fall = $time;
    falls++;
  end
  always @(negedge sda_line) if (scl_line) starts++;
  always @(posedge sda_line) if (scl_line) stops++;

  function automatic int exp_phase_ns(input logic [7:0] d);
    int n = (d < 8'd1) ? 2 : int'(d) + 1;
    return n * 5;
  endfunction

  function automatic logic [7:0] stat_word(input logic done, busy, nak, aw);
    return {4'b0, aw, nak, busy, done};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // transmit a byte; slave acknowledges when ack is 1
  task automatic send_byte(input logic [7:0] b, input logic ack);
    slave_low = 1'b0;
    wreg(2'd2, b);
    repeat (8) @(negedge scl_line);
    slave_low = ack;
    @(negedge scl_line);
    slave_low = 1'b0;
    idle(2);
  endtask

  // receive a byte supplied by the slave; prev is the data read that launched it
  task automatic recv_byte(input logic [7:0] v, output logic [7:0] prev);
    slave_low = !v[7];
    rreg(2'd2, prev);
    for (int i = 6; i >= 0; i--) begin
      @(negedge scl_line);
      slave_low = !v[i];
    end
    @(negedge scl_line);
    slave_low = 1'b0;
    @(negedge scl_line);
    idle(2);
  endtask

  initial begin : watchdog
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] rd, prev, b, last_rx;
    logic ack;
    int f0, exp_starts, exp_stops;
    void'($urandom(32'h1c2b));

    idle(3); rst_n = 1'b1; idle(2);
    starts = 0; stops = 0; falls = 0;
    exp_starts = 0; exp_stops = 0;

    // R1 reset state
    rreg(2'd2, rd); chk("R1 data", rd, 8'h00);
    rreg(2'd1, rd); chk("R1 status", rd, 8'h00);
    rreg(2'd0, rd); chk("R1 control", rd, 8'h00);
    rreg(2'd3, rd); chk("R1 divider", rd, DIVR);
    chk("R1 lines", {scl_oe, sda_oe}, 0);

    // R2 / R5 START
    wreg(2'd0, 8'h03); idle(20); exp_starts++;
    chk("R2 start seen", starts, exp_starts);
    rreg(2'd1, rd); chk("R2 R5 status after start", rd, stat_word(0, 1, 0, 1));

    // R3 / R5 address byte, write direction
    b = {7'($urandom), 1'b0};
    send_byte(b, 1'b1);
    chk("R3 R5 address bits", mon_sh[8:1], b);
    rreg(2'd1, rd); chk("R4 R5 status after address", rd, stat_word(1, 1, 0, 0));
    chk("R12 high phase", int'(last_high), exp_phase_ns(cur_div));
    chk("R12 low phase", int'(last_low), exp_phase_ns(cur_div));

    // R4 write-one-to-clear
    wreg(2'd1, 8'h00); rreg(2'd1, rd); chk("R4 write zero keeps done", rd[0], 1);
    wreg(2'd1, 8'h01); rreg(2'd1, rd); chk("R4 write one clears done", rd[0], 0);

    // R3 / R9 / R12 random data bytes with random acknowledge and divider
    for (int k = 0; k < 6; k++) begin
      cur_div = (k == 2) ? 8'd0 : 8'($urandom_range(1, 7));
      wreg(2'd3, cur_div);
      b = 8'($urandom); ack = 1'($urandom);
      send_byte(b, ack);
      chk("R3 data bits", mon_sh[8:1], b);
      rreg(2'd1, rd); chk("R3 R4 status nak/done", rd, stat_word(1, 1, !ack, 0));
      chk("R12 high phase", int'(last_high), exp_phase_ns(cur_div));
      chk("R12 low phase", int'(last_low), exp_phase_ns(cur_div));
      wreg(2'd1, 8'h01);
      f0 = falls;
      rreg(2'd2, rd); chk("R9 no readback of sent byte", rd, 8'h00);
      idle(30);
      chk("R8 no clocks on transmit read", falls, f0);
    end

    // R11 repeated START, then address with read flag
    wreg(2'd0, 8'h0B); idle(40); exp_starts++;
    chk("R11 repeated start", starts, exp_starts);
    chk("R11 no stop", stops, exp_stops);
    rreg(2'd1, rd); chk("R5 awaiting address after restart", rd[3], 1);
    b = {7'($urandom), 1'b1};
    send_byte(b, 1'b1);
    chk("R5 read address bits", mon_sh[8:1], b);
    wreg(2'd1, 8'h01);

    // R6 / R7 reception with ACK
    wreg(2'd0, 8'h01);
    last_rx = 8'h00;
    for (int k = 0; k < 4; k++) begin
      b = 8'($urandom);
      recv_byte(b, prev);
      chk("R6 read returns previous byte", prev, last_rx);
      chk("R6 bits on bus", mon_sh[8:1], b);
      chk("R7 master ACK", mon_sh[0], 0);
      rreg(2'd1, rd); chk("R4 done after receive", rd[0], 1);
      wreg(2'd1, 8'h01);
      last_rx = b;
    end

    // R7 final byte with NACK
    wreg(2'd0, 8'h05);
    b = 8'($urandom);
    recv_byte(b, prev);
    chk("R6 read returns previous byte", prev, last_rx);
    chk("R7 final NACK", mon_sh[0], 1);
    last_rx = b;

    // R8 switch to transmit, then collect last byte without a new receive
    wreg(2'd0, 8'h03);
    wreg(2'd1, 8'h01);
    f0 = falls;
    rreg(2'd2, rd); chk("R8 last byte collected", rd, last_rx);
    idle(40);
    chk("R8 no SCL edges", falls, f0);
    rreg(2'd1, rd); chk("R8 done stays clear", rd[0], 0);
    rreg(2'd2, rd); chk("R6 data holds last byte", rd, last_rx);

    // R10 STOP
    wreg(2'd0, 8'h00); idle(60); exp_stops++;
    chk("R10 stop seen", stops, exp_stops);
    rreg(2'd1, rd); chk("R10 busy clear", rd[1], 0);
    chk("R10 lines released", {scl_oe, sda_oe}, 0);

    // second short transaction after STOP
    wreg(2'd0, 8'h03); idle(20); exp_starts++;
    b = {7'($urandom), 1'b0};
    send_byte(b, 1'b0);
    rreg(2'd1, rd); chk("R3 no acknowledge seen", rd[2], 1);
    wreg(2'd0, 8'h00); idle(60); exp_stops++;

    // R13 no stray START/STOP during any data bit
    chk("R13 start count", starts, exp_starts);
    chk("R13 stop count", stops, exp_stops);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule